// File: doc/BRIEF.md
# HDQ Single-Wire Bus Master

This block drives a single-wire HDQ bus to a battery gauge. A request carries a command byte (address plus direction flag) and, for writes, one data byte. The master opens with a long low break and a short recovery. It then sends the command byte least significant bit first. Each bit is a fixed-length cell whose low part encodes the value. After the command, the master either sends the data byte or releases the wire and decodes eight bits sent back by the slave.

All timing runs on a sample strobe `tick_i`, one clock wide, nominally every 20 microseconds. Every duration is a parameter counted in those ticks. The wire is open-drain: `line_oe_o` enables the driver, `line_do_o` is the driven level, and `line_di_i` is the sampled level. An external pull-up holds the wire high whenever nobody drives it. Each timeout in the receive path ends the transaction with its own error code.

Top module: `hdq_master`

## Requirements
- R1: Apart from accepting a request, every change of `line_oe_o` and `line_do_o` happens on a clock edge where `tick_i` is high. A transaction begins on the first tick after acceptance.
- R2: A transaction starts with the wire driven low for 10 ticks (break), followed by 3 ticks driven high (recovery).
- R3: The command byte is sent bit 0 first. A 1 bit is low for 2 ticks, a 0 bit is low for 6 ticks, and every bit cell lasts 10 ticks in total, with the remainder driven high.
- R4: When command bit 7 is 1, the wire stays driven high for 15 ticks after the last command cell. The data byte is then sent with the same coding, and the transaction ends with error code 0.
- R5: When command bit 7 is 0, the master releases the wire after the last command cell. If no low level is sampled within 150 ticks, the transaction ends with error code 1.
- R6: A received bit whose low lasted at most 3 sampled ticks decodes as 1; a longer low decodes as 0. The first received bit lands in `rdata_o` bit 0. Eight bits complete the read with error code 0.
- R7: If a received low lasts longer than 15 ticks after its first low sample, the transaction ends with error code 2.
- R8: If the wire stays high for 50 ticks while the master waits for the next received bit, the transaction ends with error code 3.
- R9: The wire is released (`line_oe_o` = 0) whenever the block is idle, including right after every completion or abort.
- R10: `done_o` is high for exactly one clock at the end of each transaction, on the first cycle with `busy_o` low. `err_o` and `rdata_o` then hold until the next request.
- R11: `req_i` is accepted only while `busy_o` is low. A request made while busy is dropped, is not queued and does not change the transaction in progress.
- R12: After reset, `busy_o`, `done_o`, `line_oe_o`, `err_o` and `rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe, one clock wide |
| req_i | input | 1 | Start a transaction |
| cmd_i | input | 8 | Command byte; bit 7 = 1 for write |
| wdata_i | input | 8 | Data byte for writes |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 2 | 0 ok, 1 no response, 2 low too long, 3 next bit missing |
| rdata_o | output | 8 | Received byte |
| line_oe_o | output | 1 | Wire driver enable |
| line_do_o | output | 1 | Level driven while enabled |
| line_di_i | input | 1 | Sampled wire level |

## Verification
A wrong state or tick count shows on the wire within one bit cell: a break, low phase or high phase is off by whole ticks, or a cell no longer totals 10 ticks. Such an error appears in the pulse widths the bench measures well before the transaction ends. A decoder or timeout fault shows only at the end, as a wrong `err_o` or `rdata_o` on the `done_o` pulse, or as a missing or doubled pulse. The receive threshold is tested with slave lows of exactly 3 and 4 ticks.

// File: rtl/hdq_pkg.sv
package hdq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_BREAK, ST_RECOV, ST_TX_LOW, ST_TX_HIGH,
    ST_GAP, ST_RX_WAIT, ST_RX_LOW, ST_RX_HIGH
  } hdq_state_e;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_NO_RESP   = 2'd1;
  localparam logic [1:0] ERR_LOW_LONG  = 2'd2;
  localparam logic [1:0] ERR_HIGH_LONG = 2'd3;
endpackage

// File: rtl/hdq_phase_timer.sv
module hdq_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // phase of N ticks ends on the Nth tick after load
  assign expire_o = tick_i && (cnt_q == TW'(1));
endmodule

// File: rtl/hdq_tx_shifter.sv
module hdq_tx_shifter
  import hdq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              next_bit_o,
  output logic              last_o
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CW-1:0]     left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      left_q <= CW'(BYTE_W);
    end else if (shift_i) begin
      sh_q   <= {1'b0, sh_q[BYTE_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o      = sh_q[0];
  assign next_bit_o = sh_q[1];
  assign last_o     = (left_q == CW'(1));
endmodule

// File: rtl/hdq_rx_sampler.sv
module hdq_rx_sampler
  import hdq_pkg::*;
#(
  parameter int LW  = 5,
  parameter int THR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              begin_i,
  input  logic              count_i,
  input  logic              capture_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              last_o
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [LW-1:0]     low_q;
  logic [CW-1:0]     got_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      got_q  <= '0;
      data_q <= '0;
    end else begin
      if (clear_i) begin
        got_q  <= '0;
        data_q <= '0;
      end else if (capture_i) begin
        data_q <= {(low_q <= LW'(THR)), data_q[BYTE_W-1:1]};
        got_q  <= got_q + 1'b1;
      end
      if (begin_i)      low_q <= LW'(1);
      else if (count_i) low_q <= low_q + 1'b1;
    end
  end

  assign data_o = data_q;
  assign last_o = (got_q == CW'(BYTE_W - 1));
endmodule

// File: rtl/hdq_master.sv
module hdq_master
  import hdq_pkg::*;
#(
  parameter int BREAK_TICKS   = 10,
  parameter int RECOV_TICKS   = 3,
  parameter int ONE_LOW_TICKS = 2,
  parameter int ZERO_LOW_TICKS = 6,
  parameter int CELL_TICKS    = 10,
  parameter int GAP_TICKS     = 15,
  parameter int RX_WAIT_TICKS = 150,
  parameter int LOW_TO_TICKS  = 15,
  parameter int HIGH_TO_TICKS = 50,
  parameter int ONE_MAX_TICKS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic [7:0]  cmd_i,
  input  logic [7:0]  wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  err_o,
  output logic [7:0]  rdata_o,
  output logic        line_oe_o,
  output logic        line_do_o,
  input  logic        line_di_i
);
  localparam int M1   = (RX_WAIT_TICKS > HIGH_TO_TICKS) ? RX_WAIT_TICKS : HIGH_TO_TICKS;
  localparam int M2   = (GAP_TICKS > BREAK_TICKS) ? GAP_TICKS : BREAK_TICKS;
  localparam int M3   = (CELL_TICKS > LOW_TO_TICKS) ? CELL_TICKS : LOW_TO_TICKS;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M12 > M3) ? M12 : M3;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(LOW_TO_TICKS + 2);

  hdq_state_e        state_q, state_d;
  logic              oe_q, oe_d, do_q, do_d, done_q, done_d;
  logic [1:0]        err_q, err_d;
  logic [BYTE_W-1:0] cmd_q, wd_q;
  logic              data_ph_q, data_ph_d;
  logic              accept;

  logic              t_load, t_exp;
  logic [TW-1:0]     t_val;
  logic              tx_load, tx_shift, tx_bit, tx_next, tx_last;
  logic [BYTE_W-1:0] tx_data;
  logic              rx_clear, rx_begin, rx_count, rx_capture, rx_last;

  function automatic logic [TW-1:0] low_len(input logic b);
    return b ? TW'(ONE_LOW_TICKS) : TW'(ZERO_LOW_TICKS);
  endfunction

  hdq_phase_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .load_i(t_load), .load_val_i(t_val), .expire_o(t_exp)
  );

  hdq_tx_shifter u_tx (
    .clk_i, .rst_ni,
    .load_i(tx_load), .data_i(tx_data), .shift_i(tx_shift),
    .bit_o(tx_bit), .next_bit_o(tx_next), .last_o(tx_last)
  );

  hdq_rx_sampler #(.LW(LW), .THR(ONE_MAX_TICKS)) u_rx (
    .clk_i, .rst_ni,
    .clear_i(rx_clear), .begin_i(rx_begin), .count_i(rx_count),
    .capture_i(rx_capture), .data_o(rdata_o), .last_o(rx_last)
  );

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d    = state_q;
    oe_d       = oe_q;
    do_d       = do_q;
    err_d      = err_q;
    done_d     = 1'b0;
    data_ph_d  = data_ph_q;
    t_load     = 1'b0;
    t_val      = '0;
    tx_load    = 1'b0;
    tx_data    = cmd_q;
    tx_shift   = 1'b0;
    rx_clear   = 1'b0;
    rx_begin   = 1'b0;
    rx_count   = 1'b0;
    rx_capture = 1'b0;

    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d   = ST_ARM;
        err_d     = ERR_NONE;
        data_ph_d = 1'b0;
        rx_clear  = 1'b1;
      end
      ST_ARM: if (tick_i) begin
        state_d = ST_BREAK;
        oe_d    = 1'b1;
        do_d    = 1'b0;
        t_load  = 1'b1;
        t_val   = TW'(BREAK_TICKS);
      end
      ST_BREAK: if (t_exp) begin
        state_d = ST_RECOV;
        do_d    = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(RECOV_TICKS);
      end
      ST_RECOV: if (t_exp) begin
        state_d = ST_TX_LOW;
        tx_load = 1'b1;
        do_d    = 1'b0;
        t_load  = 1'b1;
        t_val   = low_len(cmd_q[0]);
      end
      ST_TX_LOW: if (t_exp) begin
        state_d = ST_TX_HIGH;
        do_d    = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(CELL_TICKS) - low_len(tx_bit);
      end
      ST_TX_HIGH: if (t_exp) begin
        tx_shift = 1'b1;
        t_load   = 1'b1;
        if (!tx_last) begin
          state_d = ST_TX_LOW;
          do_d    = 1'b0;
          t_val   = low_len(tx_next);
        end else if (data_ph_q) begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
          done_d  = 1'b1;
          err_d   = ERR_NONE;
        end else if (cmd_q[7]) begin
          state_d = ST_GAP;
          t_val   = TW'(GAP_TICKS);
        end else begin
          state_d = ST_RX_WAIT;
          oe_d    = 1'b0;
          t_val   = TW'(RX_WAIT_TICKS);
        end
      end
      ST_GAP: if (t_exp) begin
        state_d   = ST_TX_LOW;
        data_ph_d = 1'b1;
        tx_load   = 1'b1;
        tx_data   = wd_q;
        do_d      = 1'b0;
        t_load    = 1'b1;
        t_val     = low_len(wd_q[0]);
      end
      ST_RX_WAIT: if (tick_i) begin
        if (!line_di_i) begin
          state_d  = ST_RX_LOW;
          rx_begin = 1'b1;
          t_load   = 1'b1;
          t_val    = TW'(LOW_TO_TICKS);
        end else if (t_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = ERR_NO_RESP;
        end
      end
      ST_RX_LOW: if (tick_i) begin
        if (line_di_i) begin
          rx_capture = 1'b1;
          if (rx_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = ERR_NONE;
          end else begin
            state_d = ST_RX_HIGH;
            t_load  = 1'b1;
            t_val   = TW'(HIGH_TO_TICKS);
          end
        end else begin
          rx_count = 1'b1;
          if (t_exp) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = ERR_LOW_LONG;
          end
        end
      end
      ST_RX_HIGH: if (tick_i) begin
        if (!line_di_i) begin
          state_d  = ST_RX_LOW;
          rx_begin = 1'b1;
          t_load   = 1'b1;
          t_val    = TW'(LOW_TO_TICKS);
        end else if (t_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = ERR_HIGH_LONG;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
      do_q      <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= ERR_NONE;
      data_ph_q <= 1'b0;
      cmd_q     <= '0;
      wd_q      <= '0;
    end else begin
      state_q   <= state_d;
      oe_q      <= oe_d;
      do_q      <= do_d;
      done_q    <= done_d;
      err_q     <= err_d;
      data_ph_q <= data_ph_d;
      if (accept) begin
        cmd_q <= cmd_i;
        wd_q  <= wdata_i;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign line_oe_o = oe_q;
  assign line_do_o = do_q;
endmodule

// File: rtl/hdq_master_chk.sv
module hdq_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       req_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] err_o,
  input logic [7:0] rdata_o,
  input logic       line_oe_o,
  input logic       line_do_o
);
  assert_wire_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> $stable(line_oe_o) && $stable(line_do_o));

  assert_idle_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_oe_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_on_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !req_i |=> $stable(err_o) && $stable(rdata_o));

  assert_no_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o);
endmodule

bind hdq_master hdq_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
  .line_oe_o(line_oe_o), .line_do_o(line_do_o)
);

// File: tb/tb_hdq_master.sv
`timescale 1ns/1ps
module tb_hdq_master;
  localparam int TDIV = 4;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] wd;
    logic [7:0] rep;
    logic [3:0] lo1;
    logic [3:0] lo0;
    logic [1:0] mode;   // 0 reply, 1 silent, 2 stuck low, 3 stop after 3 bits
    logic [1:0] err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h85, 8'h3C, 8'h00, 4'd2, 4'd6, 2'd0, 2'd0},
    '{8'hFF, 8'h00, 8'h00, 4'd2, 4'd6, 2'd0, 2'd0},
    '{8'h05, 8'h00, 8'hA5, 4'd2, 4'd6, 2'd0, 2'd0},
    '{8'h00, 8'h00, 8'h5A, 4'd3, 4'd4, 2'd0, 2'd0},
    '{8'h7F, 8'h00, 8'hFF, 4'd2, 4'd6, 2'd0, 2'd0},
    '{8'h12, 8'h00, 8'h00, 4'd2, 4'd6, 2'd1, 2'd1},
    '{8'h13, 8'h00, 8'h00, 4'd2, 4'd6, 2'd2, 2'd2},
    '{8'h14, 8'h00, 8'h07, 4'd2, 4'd6, 2'd3, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0;
  logic [7:0] cmd = '0, wd = '0;
  logic busy, done, oe, dout, slave_low = 1'b0;
  logic [1:0] err;
  logic [7:0] rdata;
  wire line = oe ? dout : !slave_low;

  int n_chk = 0, n_bad = 0, cyc = 0, div = 0;
  int lows [64];
  int highs [64];
  int nl, nh, run, done_cnt;
  logic prev, mon_en = 1'b0;

  always #4 clk = ~clk;

  hdq_master dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .cmd_i(cmd),
    .wdata_i(wd), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .line_oe_o(oe), .line_do_o(dout), .line_di_i(line)
  );

  always @(negedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == TDIV - 1);
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // pulse-width monitor in clocks
  always @(negedge clk) if (mon_en) begin
    if (done) done_cnt++;
    if (line == prev) run++;
    else begin
      if (prev) begin if (nh < 64) highs[nh] = run; nh++; end
      else      begin if (nl < 64) lows[nl]  = run; nl++; end
      run = 1;
      prev = line;
    end
  end

  task automatic check(input string r, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", r, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic slave_pulse(input int l);
    slave_low = 1'b1;
    wait_ticks(l);
    slave_low = 1'b0;
  endtask

  task automatic slave(input vec_t v);
    @(negedge oe);
    wait_ticks(5);
    case (v.mode)
      2'd0: for (int b = 0; b < 8; b++) begin
        slave_pulse(v.rep[b] ? int'(v.lo1) : int'(v.lo0));
        if (b < 7) wait_ticks(4);
      end
      2'd2: slave_pulse(20);
      2'd3: for (int b = 0; b < 3; b++) begin
        slave_pulse(v.rep[b] ? int'(v.lo1) : int'(v.lo0));
        wait_ticks(4);
      end
      default: ;
    endcase
  endtask

  task automatic start(input logic [7:0] c, input logic [7:0] w);
    nl = 0; nh = 0; run = 0; prev = 1'b1; done_cnt = 0; mon_en = 1'b1;
    @(negedge clk);
    cmd = c; wd = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic check_tx(input logic [7:0] c, input logic [7:0] w, input bit is_wr);
    int bits_ok, cells_ok;
    check("R2", lows[0] / TDIV, 10, "break ticks");
    check("R2", highs[1] / TDIV, 3, "recovery ticks");
    bits_ok = 1; cells_ok = 1;
    for (int i = 1; i <= 8; i++) begin
      if (lows[i] != (c[i-1] ? 2 : 6) * TDIV) bits_ok = 0;
      if (i < 8 && lows[i] + highs[i+1] != 10 * TDIV) cells_ok = 0;
    end
    check("R3", bits_ok, 1, "command bit lows");
    check("R3", cells_ok, 1, "command cell length");
    if (is_wr) begin
      check("R4", highs[9] / TDIV, 10 - (c[7] ? 2 : 6) + 15, "gap ticks");
      bits_ok = 1;
      for (int i = 9; i <= 16; i++)
        if (lows[i] != (w[i-9] ? 2 : 6) * TDIV) bits_ok = 0;
      check("R4", bits_ok, 1, "data bit lows");
    end
  endtask

  task automatic run_vec(input vec_t v);
    start(v.cmd, v.wd);
    fork
      if (!v.cmd[7]) slave(v);
      wait (done_cnt > 0);
    join
    repeat (20) @(negedge clk);
    mon_en = 1'b0;
    check("R10", done_cnt, 1, "done pulses");
    check("R9", oe, 0, "wire released");
    check(v.err == 2'd0 ? (v.cmd[7] ? "R4" : "R6") :
          v.err == 2'd1 ? "R5" : v.err == 2'd2 ? "R7" : "R8",
          err, v.err, "error code");
    if (!v.cmd[7] && v.err == 2'd0) check("R6", rdata, v.rep, "read data");
    check_tx(v.cmd, v.wd, v.cmd[7]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", busy, 0, "busy after reset");
    check("R12", done, 0, "done after reset");
    check("R12", oe, 0, "oe after reset");
    check("R12", err, 0, "err after reset");
    check("R12", rdata, 0, "rdata after reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: start waits for a tick
    start(8'h81, 8'h55);
    check("R1", oe, 0, "no drive before first tick");
    // R11: second request while busy is dropped
    repeat (40) @(negedge clk);
    cmd = 8'h02; wd = 8'hFF; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait (done_cnt > 0);
    repeat (100) @(negedge clk);
    mon_en = 1'b0;
    check("R11", busy, 0, "no queued request");
    check("R11", done_cnt, 1, "single completion");
    check_tx(8'h81, 8'h55, 1'b1);

    // R10: results hold after a read
    run_vec(VECS[2]);
    repeat (60) @(negedge clk);
    check("R10", rdata, 8'hA5, "rdata held");
    check("R10", err, 0, "err held");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule